// File: doc/BRIEF.md
# Link-Gated Streaming Transmit Controller

This block connects an upstream producer of narrow samples to a downstream serial-link transmit core. Both sides use a valid/ready handshake. Each accepted sample is widened to the downstream word width by filling the upper bits with zeros. The sample then passes through a two-entry skid buffer. The buffer keeps one transfer per cycle and drives the upstream ready from a flop.

Words are offered downstream only while the link reports its data phase. That means three status inputs are all high: code-group synchronisation finished, initial lane alignment finished, and link up. If any of the three falls, the block withdraws its offer at once. It keeps every sample it has already accepted and resumes in the original order when all three are high again. A running count of accepted samples lets the surrounding logic compare the number of samples taken in with the number delivered.

Top module: `link_gated_tx`

## Requirements
- R1: A transfer on either side happens only on a rising clock edge where that side's valid and ready are both high.
- R2: Each delivered word carries the accepted sample in bits [IN_W-1:0], and bits [OUT_W-1:IN_W] are zero.
- R3: With the link in its data phase, upstream valid held high and downstream ready held high, one sample is accepted and one word is delivered on every cycle.
- R4: Downstream valid is high only in a cycle where the sync-done, align-done and link-up inputs are all high.
- R5: Samples are delivered in the order they were accepted, and none is lost or duplicated, across any number of link drops.
- R6: A sample that is held in the buffer when the link drops is the first word delivered after all three flags return high.
- R7: While the downstream side is blocked, no more than two samples are accepted, and upstream ready is low while two are held.
- R8: While downstream valid is high and downstream ready is low, the downstream data does not change in the next cycle.
- R9: While reset is asserted, downstream valid is low, upstream ready is low and the accepted count is zero. Upstream ready rises on the first clock edge after reset is released.
- R10: The accepted-sample count equals the number of upstream transfers since reset. It changes one cycle after each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| up_valid | input | 1 | Upstream sample valid |
| up_ready | output | 1 | Upstream ready, driven from a flop |
| up_sample | input | IN_W | Upstream sample |
| dn_valid | output | 1 | Downstream word valid, gated by the link status |
| dn_ready | input | 1 | Downstream ready |
| dn_word | output | OUT_W | Zero-padded downstream word |
| lnk_sync_done | input | 1 | Code-group synchronisation finished |
| lnk_align_done | input | 1 | Initial lane alignment finished |
| lnk_up | input | 1 | Link up |
| accepted_count | output | CNT_W | Number of samples accepted since reset |

## Verification
The hardest state to reach is a link drop while the skid buffer is full and a downstream word is stalled. The stall has to outlast the drop, and recovery must then release the held words in order. Random phases drop one of the three flags at a time for one to eight cycles. These drops mix with low downstream-ready rates and bursty upstream traffic, so the buffer is often full when a flag falls. Directed cases add a single held sample across a drop, a fully blocked sink, and a full-rate stream.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

  // Occupancy of the two-entry skid buffer.
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_TWO  = 2'd2
  } fill_e;

  // Number of link status flags that must all be high.
  localparam int unsigned LINK_FLAGS = 3;

endpackage

// File: rtl/ltx_pad.sv
module ltx_pad #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  narrow,
  output logic [OUT_W-1:0] wide
);
  localparam int unsigned PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign wide = {{PAD_W{1'b0}}, narrow};
    end else begin : g_pass
      assign wide = narrow;
    end
  endgenerate
endmodule

// File: rtl/ltx_link_gate.sv
module ltx_link_gate #(
  parameter int unsigned NFLAG = ltx_pkg::LINK_FLAGS
) (
  input  logic [NFLAG-1:0] flags,
  input  logic             buf_valid,
  input  logic             sink_ready,
  output logic             out_valid,
  output logic             buf_pop_ready
);
  logic link_ok;

  assign link_ok       = &flags;
  assign out_valid     = buf_valid & link_ok;
  assign buf_pop_ready = sink_ready & link_ok;
endmodule

// File: rtl/ltx_skid.sv
module ltx_skid #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  import ltx_pkg::*;

  fill_e        fill_q, fill_d;
  logic [W-1:0] head_q, head_d;
  logic [W-1:0] spare_q;
  logic         head_en, spare_en;
  logic         ready_q, ready_d;
  logic         push, pop;

  assign push = in_valid & ready_q;
  assign pop  = (fill_q != FILL_NONE) & out_ready;

  always_comb begin
    fill_d   = fill_q;
    head_d   = in_data;
    head_en  = 1'b0;
    spare_en = 1'b0;
    unique case (fill_q)
      FILL_NONE: begin
        if (push) begin
          head_en = 1'b1;
          fill_d  = FILL_ONE;
        end
      end
      FILL_ONE: begin
        if (push && pop) begin
          head_en = 1'b1;
        end else if (push) begin
          spare_en = 1'b1;
          fill_d   = FILL_TWO;
        end else if (pop) begin
          fill_d = FILL_NONE;
        end
      end
      FILL_TWO: begin
        if (pop) begin
          head_d  = spare_q;
          head_en = 1'b1;
          fill_d  = FILL_ONE;
        end
      end
      default: fill_d = FILL_NONE;
    endcase
    ready_d = (fill_d != FILL_TWO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= FILL_NONE;
      ready_q <= 1'b0;
    end else begin
      fill_q  <= fill_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk) begin
    if (head_en)  head_q  <= head_d;
    if (spare_en) spare_q <= in_data;
  end

  assign in_ready  = ready_q;
  assign out_valid = (fill_q != FILL_NONE);
  assign out_data  = head_q;
endmodule

// File: rtl/ltx_count.sv
module ltx_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/link_gated_tx.sv
module link_gated_tx #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [IN_W-1:0]  up_sample,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [OUT_W-1:0] dn_word,
  input  logic             lnk_sync_done,
  input  logic             lnk_align_done,
  input  logic             lnk_up,
  output logic [CNT_W-1:0] accepted_count
);
  localparam int unsigned NFLAG = ltx_pkg::LINK_FLAGS;

  logic [OUT_W-1:0] padded;
  logic             buf_valid;
  logic             buf_pop_ready;
  logic             up_ready_int;
  logic [NFLAG-1:0] flag_vec;

  assign flag_vec = {lnk_up, lnk_align_done, lnk_sync_done};

  ltx_pad #(.IN_W(IN_W), .OUT_W(OUT_W)) u_pad (
    .narrow (up_sample),
    .wide   (padded)
  );

  ltx_skid #(.W(OUT_W)) u_skid (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (up_valid),
    .in_ready  (up_ready_int),
    .in_data   (padded),
    .out_valid (buf_valid),
    .out_ready (buf_pop_ready),
    .out_data  (dn_word)
  );

  ltx_link_gate #(.NFLAG(NFLAG)) u_gate (
    .flags         (flag_vec),
    .buf_valid     (buf_valid),
    .sink_ready    (dn_ready),
    .out_valid     (dn_valid),
    .buf_pop_ready (buf_pop_ready)
  );

  ltx_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (up_valid & up_ready_int),
    .value (accepted_count)
  );

  assign up_ready = up_ready_int;
endmodule

// File: rtl/ltx_checker.sv
module ltx_checker #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic             up_ready,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [OUT_W-1:0] dn_word,
  input logic             lnk_sync_done,
  input logic             lnk_align_done,
  input logic             lnk_up,
  input logic [CNT_W-1:0] accepted_count
);
  logic [2:0] occ_q;
  logic       up_hs, dn_hs;

  assign up_hs = up_valid & up_ready;
  assign dn_hs = dn_valid & dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + {2'b0, up_hs} - {2'b0, dn_hs};
  end

  // R4
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (lnk_sync_done && lnk_align_done && lnk_up));

  // R2
  p_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_word[OUT_W-1:IN_W] == '0));

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> $stable(dn_word));

  // R7
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == 3'd2) |-> !up_ready);

  // R7
  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 3'd2);

  // R10
  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    up_hs |=> (accepted_count == $past(accepted_count) + 1'b1));

  // R5
  p_no_phantom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == 3'd0) |-> !dn_valid);
endmodule

bind link_gated_tx ltx_checker #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .up_valid       (up_valid),
  .up_ready       (up_ready),
  .dn_valid       (dn_valid),
  .dn_ready       (dn_ready),
  .dn_word        (dn_word),
  .lnk_sync_done  (lnk_sync_done),
  .lnk_align_done (lnk_align_done),
  .lnk_up         (lnk_up),
  .accepted_count (accepted_count)
);

// File: tb/sim_link_gated_tx.sv
module sim_link_gated_tx;
  localparam int unsigned IN_W  = 16;
  localparam int unsigned OUT_W = 32;
  localparam int unsigned CNT_W = 32;
  localparam int CLK_P = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             up_valid;
  logic             up_ready;
  logic [IN_W-1:0]  up_sample;
  logic             dn_valid;
  logic             dn_ready;
  logic [OUT_W-1:0] dn_word;
  logic             f_sync, f_align, f_up;
  logic [CNT_W-1:0] accepted_count;

  link_gated_tx #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_sample(up_sample),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_word(dn_word),
    .lnk_sync_done(f_sync), .lnk_align_done(f_align), .lnk_up(f_up),
    .accepted_count(accepted_count)
  );

  always #(CLK_P/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [OUT_W-1:0] exp_q[$];
  int unsigned acc_n = 0;
  int unsigned del_n = 0;
  int unsigned src_pct = 0, snk_pct = 0, drop_pct = 0;
  int unsigned src_budget = 0;
  int unsigned drop_left = 0;
  bit last_up_hs = 1;
  bit up_hs_now, dn_hs_now;
  bit prev_hold = 0;
  logic [OUT_W-1:0] prev_word;
  logic [OUT_W-1:0] last_pushed;
  logic [OUT_W-1:0] last_delivered;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [OUT_W-1:0] pad_exp(input logic [IN_W-1:0] s);
    return {{(OUT_W-IN_W){1'b0}}, s};
  endfunction

  // Observe the current cycle: handshakes that occur on the coming edge.
  task automatic observe();
    up_hs_now = up_valid && up_ready;
    dn_hs_now = dn_valid && dn_ready;
    if (dn_valid)
      chk(f_sync && f_align && f_up, "R4 valid with link not ready", {61'd0, f_sync, f_align, f_up}, 64'h7);
    if (prev_hold && dn_valid)
      chk(dn_word == prev_word, "R8 stalled word changed", dn_word, prev_word);
    chk(accepted_count == acc_n, "R10 accepted count", accepted_count, acc_n);
    if (dn_hs_now) begin
      chk(dn_word[OUT_W-1:IN_W] == '0, "R2 upper bits not zero", dn_word, pad_exp(dn_word[IN_W-1:0]));
      if (exp_q.size() == 0) begin
        chk(0, "R5 word delivered with nothing pending", dn_word, 0);
      end else begin
        logic [OUT_W-1:0] e;
        e = exp_q.pop_front();
        chk(dn_word == e, "R5 order or content", dn_word, e);
      end
      last_delivered = dn_word;
      del_n++;
    end
    if (up_hs_now) begin
      exp_q.push_back(pad_exp(up_sample));
      last_pushed = pad_exp(up_sample);
      acc_n++;
      if (src_budget > 0) src_budget--;
    end
    prev_hold = dn_valid && !dn_ready;
    prev_word = dn_word;
    last_up_hs = up_hs_now;
  endtask

  task automatic cycle();
    if (!(up_valid && !last_up_hs)) begin
      if (src_budget > 0 && ($urandom % 100) < src_pct) begin
        up_valid  = 1'b1;
        up_sample = IN_W'($urandom);
      end else begin
        up_valid = 1'b0;
      end
    end
    dn_ready = (($urandom % 100) < snk_pct);
    if (drop_left > 0) begin
      drop_left--;
      if (drop_left == 0) begin f_sync = 1; f_align = 1; f_up = 1; end
    end else if (drop_pct > 0 && ($urandom % 100) < drop_pct) begin
      case ($urandom % 3)
        0: f_sync = 0;
        1: f_align = 0;
        default: f_up = 0;
      endcase
      drop_left = 1 + ($urandom % 8);
    end
    #1;
    observe();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic drain();
    src_budget = 0; snk_pct = 100; drop_pct = 0;
    for (int i = 0; i < 40 && (exp_q.size() > 0 || drop_left > 0 || up_valid); i++) cycle();
    chk(exp_q.size() == 0, "R5 drain left samples", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired R5 actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; up_valid = 0; up_sample = '0; dn_ready = 0;
    f_sync = 1; f_align = 1; f_up = 1;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R9 reset state
    chk(!dn_valid, "R9 dn_valid in reset", dn_valid, 0);
    chk(!up_ready, "R9 up_ready in reset", up_ready, 0);
    chk(accepted_count == 0, "R9 count in reset", accepted_count, 0);
    rst_n = 1;
    #1;
    chk(!up_ready, "R9 up_ready before first edge", up_ready, 0);
    @(posedge clk); #(CLK_P/4);
    chk(up_ready, "R9 up_ready after first edge", up_ready, 1);

    // R3 full throughput
    begin
      int unsigned a0, d0;
      src_budget = 1000; src_pct = 100; snk_pct = 100;
      repeat (3) cycle();
      a0 = acc_n; d0 = del_n;
      repeat (40) cycle();
      chk(acc_n - a0 == 40, "R3 accept rate", acc_n - a0, 40);
      chk(del_n - d0 == 40, "R3 deliver rate", del_n - d0, 40);
    end
    drain();

    // R7 blocked sink: at most two accepted
    begin
      int unsigned a0;
      a0 = acc_n;
      src_budget = 1000; src_pct = 100; snk_pct = 0;
      repeat (10) cycle();
      chk(acc_n - a0 == 2, "R7 accepted while blocked", acc_n - a0, 2);
      chk(!up_ready, "R7 up_ready while full", up_ready, 0);
      chk(dn_valid, "R7 word offered while full", dn_valid, 1);
    end
    drain();

    // R6 held sample across a link drop
    begin
      logic [OUT_W-1:0] held;
      int unsigned d0;
      src_budget = 1; src_pct = 100; snk_pct = 0;
      repeat (3) cycle();
      held = last_pushed;
      f_up = 0;
      repeat (5) cycle();
      chk(!dn_valid, "R4 valid during drop", dn_valid, 0);
      f_align = 0; f_up = 1;
      repeat (3) cycle();
      chk(!dn_valid, "R4 valid with align low", dn_valid, 0);
      f_align = 1;
      d0 = del_n;
      snk_pct = 100;
      for (int i = 0; i < 5 && del_n == d0; i++) cycle();
      chk(last_delivered == held, "R6 first word after recovery", last_delivered, held);
    end
    drain();

    // Random phases with link drops (R1, R5, R8, R4)
    for (int ph = 0; ph < 6; ph++) begin
      src_budget = 100000;
      src_pct  = 30 + 14 * ph;
      snk_pct  = 90 - 14 * ph;
      drop_pct = 3 + 2 * ph;
      repeat (3000) cycle();
      drain();
    end

    // R10 and R5 totals
    chk(accepted_count == acc_n, "R10 final count", accepted_count, acc_n);
    chk(del_n == acc_n, "R5 delivered equals accepted", del_n, acc_n);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule